// File: doc/BRIEF.md
# Interrupt vector fetch selector

This block decides, for every interrupt vector fetch the CPU issues, whether the vector is read from an expansion vector table or from the default vector table held in boot ROM. A single enable bit in a control register routes fetches to the expansion table. The one exception is the reset vector: a fetch flagged as the reset fetch always goes to boot ROM. Each fetch that the expansion table serves stores the upper bits of its address in a read-only field of the same control register. Software can read that field to see which vector was taken last. Because the address LSB is dropped, the field reads back with the enable bit in bit 0.

The block also holds a group acknowledge register with one bit per interrupt group. Software clears a bit by writing a one to it. Interrupt logic elsewhere sets a bit again through a per-group set input. Both registers sit on a simple single-cycle register bus, and software can reach them whether or not the expansion table is enabled.

Top module: `vec_fetch_sel`

## Requirements
- R1: The enable bit is bit 0 of the control register (bus offset 0). It is read/write, and after reset the whole control register reads 0x0000.
- R2: While the enable bit is 0, `sel_exp` is 0 for every fetch, so the vector comes from the boot-ROM table.
- R3: While the enable bit is 1, a valid fetch with `fetch_rst` low drives `sel_exp` to 1 in the same cycle.
- R4: A fetch with `fetch_rst` high drives `sel_exp` to 0 whatever the enable bit holds.
- R5: A fetch served by the expansion table stores `fetch_addr[15:1]` into control bits 15:1, readable from the next cycle. The address LSB is dropped, so fetches from 0x0D26 and from 0x0D27 both read back as 0x0D27 when enabled.
- R6: Control bits 15:1 hold their value on fetches served by boot ROM and on bus writes. Bus writes to those bits have no effect.
- R7: The acknowledge register (bus offset 1) has 12 bits in positions 11:0 that reset to 1, so it reads 0x0FFF after reset. Bits 15:12 always read 0.
- R8: A bus write to the acknowledge register clears each bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R9: A high `ack_set[i]` sets acknowledge bit i on the next clock. When it coincides with a write-one clear of the same bit, the set wins.
- R10: Both registers can be read and written while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 control, 1 acknowledge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| fetch_vld | input | 1 | A vector fetch is in progress this cycle |
| fetch_rst | input | 1 | The current fetch is the reset vector |
| fetch_addr | input | DATA_W | Vector address of the current fetch |
| sel_exp | output | 1 | 1 = serve the fetch from the expansion table, 0 = boot ROM |
| ack_set | input | GRP_N | Per-group set of the acknowledge bits |
| ack_bits | output | GRP_N | Current acknowledge bits |

## Verification
The bench builds the block with its defaults: a 16-bit data path and 12 groups. With these values the captured field is a full 15 bits wide and every acknowledge bit, including the top one next to the always-zero bits, is set and cleared by random stimulus. Directed cases cover the odd-address fetch, reset-vector fetches with the table enabled, and a set colliding with a clear on the same group bit. Random cycles then mix enable toggling, fetches and sets against a reference model.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int unsigned VFS_BUS_AW = 2;

  typedef enum logic [VFS_BUS_AW-1:0] {
    VFS_REG_CTRL = 2'd0,
    VFS_REG_ACK  = 2'd1
  } vfs_reg_e;
endpackage

// File: rtl/vfs_rst_sync.sv
module vfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/vfs_ctrl_reg.sv
module vfs_ctrl_reg #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned VECT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              wr_en_bit,
  input  logic              fetch_vld,
  input  logic              fetch_rst,
  input  logic [VECT_W-1:0] fetch_hi,
  output logic              en_q,
  output logic [VECT_W-1:0] vect_q,
  output logic              sel_exp
);
  logic              en_d;
  logic [VECT_W-1:0] vect_d;
  logic              cap_en;

  always_comb begin
    sel_exp = fetch_vld & en_q & ~fetch_rst;
    cap_en  = sel_exp;
    en_d    = ctrl_wr ? wr_en_bit : en_q;
    vect_d  = cap_en ? fetch_hi : vect_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      vect_q <= '0;
    end else begin
      en_q   <= en_d;
      vect_q <= vect_d;
    end
  end
endmodule

// File: rtl/vfs_ack_reg.sv
module vfs_ack_reg #(
  parameter int unsigned GRP_N = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_stb,
  input  logic [GRP_N-1:0] clr_mask,
  input  logic [GRP_N-1:0] set_in,
  output logic [GRP_N-1:0] ack_q
);
  for (genvar g = 0; g < GRP_N; g++) begin : g_bit
    logic bit_d;
    logic clr_hit;

    always_comb begin
      clr_hit = clr_stb & clr_mask[g];
      if (set_in[g])    bit_d = 1'b1;
      else if (clr_hit) bit_d = 1'b0;
      else              bit_d = ack_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q[g] <= 1'b1;
      else        ack_q[g] <= bit_d;
    end
  end
endmodule

// File: rtl/vfs_rd_mux.sv
module vfs_rd_mux
  import vfs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GRP_N  = 12
) (
  input  logic [VFS_BUS_AW-1:0] addr,
  input  logic                  en_q,
  input  logic [DATA_W-2:0]     vect_q,
  input  logic [GRP_N-1:0]      ack_q,
  output logic [DATA_W-1:0]     rdata
);
  always_comb begin
    case (addr)
      VFS_REG_CTRL: rdata = {vect_q, en_q};
      VFS_REG_ACK:  rdata = {{(DATA_W-GRP_N){1'b0}}, ack_q};
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/vec_fetch_sel.sv
module vec_fetch_sel
  import vfs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GRP_N  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_wr,
  input  logic [VFS_BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  fetch_vld,
  input  logic                  fetch_rst,
  input  logic [DATA_W-1:0]     fetch_addr,
  output logic                  sel_exp,
  input  logic [GRP_N-1:0]      ack_set,
  output logic [GRP_N-1:0]      ack_bits
);
  localparam int unsigned VECT_W = DATA_W - 1;

  logic              rst_sync_n;
  logic              wr_stb;
  logic              ctrl_wr;
  logic              ack_wr;
  logic              en_q;
  logic [VECT_W-1:0] vect_q;
  logic              unused_bits;

  assign unused_bits = ^{fetch_addr[0], bus_wdata[DATA_W-1:GRP_N]};

  always_comb begin
    wr_stb  = bus_en & bus_wr;
    ctrl_wr = wr_stb & (bus_addr == VFS_REG_CTRL);
    ack_wr  = wr_stb & (bus_addr == VFS_REG_ACK);
  end

  vfs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vfs_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_wr   (ctrl_wr),
    .wr_en_bit (bus_wdata[0]),
    .fetch_vld (fetch_vld),
    .fetch_rst (fetch_rst),
    .fetch_hi  (fetch_addr[DATA_W-1:1]),
    .en_q      (en_q),
    .vect_q    (vect_q),
    .sel_exp   (sel_exp)
  );

  vfs_ack_reg #(.GRP_N(GRP_N)) u_ack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_stb  (ack_wr),
    .clr_mask (bus_wdata[GRP_N-1:0]),
    .set_in   (ack_set),
    .ack_q    (ack_bits)
  );

  vfs_rd_mux #(.DATA_W(DATA_W), .GRP_N(GRP_N)) u_rd (
    .addr   (bus_addr),
    .en_q   (en_q),
    .vect_q (vect_q),
    .ack_q  (ack_bits),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GRP_N  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              fetch_vld,
  input logic              fetch_rst,
  input logic [DATA_W-2:0] fetch_hi,
  input logic              sel_exp,
  input logic [DATA_W-2:0] vect_q,
  input logic [GRP_N-1:0]  ack_set,
  input logic [GRP_N-1:0]  ack_bits
);
  AST_DIS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !en_q) |-> !sel_exp); // R2
  AST_EN_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && en_q && !fetch_rst) |-> sel_exp); // R3
  AST_RST_VEC_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && fetch_rst) |-> !sel_exp); // R4
  AST_VECT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_exp |=> (vect_q == $past(fetch_hi))); // R5
  AST_VECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_exp |=> $stable(vect_q)); // R6
  AST_ACK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_set) |=> ((ack_bits & $past(ack_set)) == $past(ack_set))); // R9
  AST_ACK_NO_SPUR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ack_bits & ~$past(ack_bits) & ~$past(ack_set)) == '0)); // R9
endmodule

bind vec_fetch_sel vfs_checker #(.DATA_W(DATA_W), .GRP_N(GRP_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en_q      (en_q),
  .fetch_vld (fetch_vld),
  .fetch_rst (fetch_rst),
  .fetch_hi  (fetch_addr[DATA_W-1:1]),
  .sel_exp   (sel_exp),
  .vect_q    (vect_q),
  .ack_set   (ack_set),
  .ack_bits  (ack_bits)
);

// File: tb/vec_fetch_sel_bench.sv
module vec_fetch_sel_bench;
  localparam int unsigned DW = 16;
  localparam int unsigned GN = 12;

  logic          clk;
  logic          rst_n;
  logic          bus_en;
  logic          bus_wr;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          fetch_vld;
  logic          fetch_rst;
  logic [DW-1:0] fetch_addr;
  logic          sel_exp;
  logic [GN-1:0] ack_set;
  logic [GN-1:0] ack_bits;

  int total = 0;
  int bad   = 0;

  logic          m_en;
  logic [DW-2:0] m_vect;
  logic [GN-1:0] m_ack;

  vec_fetch_sel u_vec_fetch_sel (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fetch_vld(fetch_vld), .fetch_rst(fetch_rst), .fetch_addr(fetch_addr),
    .sel_exp(sel_exp), .ack_set(ack_set), .ack_bits(ack_bits)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic exp_sel(logic en, logic vld, logic rv);
    return vld & en & ~rv;
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [1:0] a);
    if (a == 2'd0) return {m_vect, m_en};
    if (a == 2'd1) return {{(DW-GN){1'b0}}, m_ack};
    return '0;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_en = 0; bus_wr = 0; bus_addr = 0; bus_wdata = '0;
    fetch_vld = 0; fetch_rst = 0; fetch_addr = '0; ack_set = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    if (fetch_vld && m_en && !fetch_rst) m_vect = fetch_addr[DW-1:1];
    if (bus_en && bus_wr && bus_addr == 2'd0) m_en = bus_wdata[0];
    if (bus_en && bus_wr && bus_addr == 2'd1) m_ack = m_ack & ~bus_wdata[GN-1:0];
    m_ack = m_ack | ack_set;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(string req, logic [1:0] a);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_rd(a));
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic fetch(string req, logic [DW-1:0] a, logic rv);
    fetch_vld = 1; fetch_rst = rv; fetch_addr = a;
    #1;
    chk(req, {15'd0, sel_exp}, {15'd0, exp_sel(m_en, 1'b1, rv)});
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h1d2c_3b4a;
    void'($urandom(seed));
    idle();
    rst_n = 0;
    m_en = 0; m_vect = '0; m_ack = '1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 R6 R7: reset values
    rd("R1 ctrl reset", 2'd0);
    chk("R6 vect reset", bus_rdata, 16'h0000);
    rd("R7 ack reset", 2'd1);
    chk("R7 ack reset literal", bus_rdata, 16'h0FFF);

    // R2 R6: fetch while disabled
    fetch("R2 disabled fetch", 16'h0D26, 1'b0);
    rd("R6 no capture when disabled", 2'd0);

    // R1: enable
    wr(2'd0, 16'h0001);
    rd("R1 enable readback", 2'd0);
    chk("R1 enable literal", bus_rdata, 16'h0001);

    // R3 R5: expansion fetch and capture
    fetch("R3 enabled fetch", 16'h0D26, 1'b0);
    rd("R5 capture even", 2'd0);
    chk("R5 capture literal", bus_rdata, 16'h0D27);
    fetch("R3 odd fetch", 16'h0D27, 1'b0);
    rd("R5 lsb dropped", 2'd0);
    chk("R5 lsb dropped literal", bus_rdata, 16'h0D27);

    // R4 R6: reset vector while enabled
    fetch("R4 reset vector", 16'h0000, 1'b1);
    rd("R6 hold on reset fetch", 2'd0);
    chk("R6 hold literal", bus_rdata, 16'h0D27);

    // R6 R1: write upper bits ignored, disable
    wr(2'd0, 16'hFFFE);
    rd("R6 write ignored", 2'd0);
    chk("R6 write ignored literal", bus_rdata, 16'h0D26);
    fetch("R4 reset vector disabled", 16'h0002, 1'b1);

    // R8 R10: clear while disabled
    wr(2'd1, 16'h0005);
    rd("R8 clear", 2'd1);
    chk("R10 clear while disabled", bus_rdata, 16'h0FFA);

    // R9: set beats clear on same bit
    bus_en = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 16'h0003;
    ack_set = 12'h001;
    tick();
    rd("R9 set wins", 2'd1);
    chk("R9 set wins literal", bus_rdata, 16'h0FF9);

    // R7: upper write bits do nothing, read zero
    wr(2'd1, 16'hF000);
    rd("R7 upper bits", 2'd1);
    chk("R7 upper bits literal", bus_rdata, 16'h0FF9);

    // random mix: R1 R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 4;
      bus_addr = 2'($urandom % 2);
      if (op == 0) begin
        bus_en = 1; bus_wr = 1; bus_wdata = 16'($urandom);
      end else if (op == 1) begin
        bus_en = 1; bus_wr = 0;
      end
      fetch_vld  = ($urandom % 2) == 1;
      fetch_rst  = ($urandom % 5) == 0;
      fetch_addr = 16'($urandom);
      ack_set    = (($urandom % 6) == 0) ? 12'($urandom) : '0;
      #1;
      chk("R2 R3 R4 random select", {15'd0, sel_exp},
          {15'd0, exp_sel(m_en, fetch_vld, fetch_rst)});
      chk("R8 R9 random ack pins", {4'd0, ack_bits}, {4'd0, m_ack});
      if (bus_en && !bus_wr) chk("R1 R5 R6 random read", bus_rdata, exp_rd(bus_addr));
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule